// File: doc/BRIEF.md
# Spanning-Tree Port State Filter

This block sits beside the lookup stage of a small multi-port Ethernet switch that runs rapid spanning tree. It gates each frame's forwarding and address learning. Every port carries three control bits: transmit enable, receive enable and learning off. The three legal combinations give the discarding, learning and forwarding conditions of a port. For each frame descriptor (source port, destination port mask, static-table hit, override flag, multicast source address) the block decides, one cycle later, which ports the frame may leave on and whether the source address may be learned.

Two exceptions let spanning-tree control traffic through ports that are not forwarding. A frame that hits a static entry with its override flag set always reaches the management port, even when its ingress port is not receiving. Frames that the management processor sends may leave on ports in the learning condition. When a port's learning is switched off, the block raises a one-cycle flush request that names the port, so the address tables can drop that port's entries.

Control writes go to a pending copy. The pending copy becomes active only on a cycle with no descriptor, so a frame is never judged by a mix of old and new settings.

Top module: `stp_port_gate`

## Requirements
- R1: After reset every port is discarding (transmit 0, receive 0, learning off 1). The outputs `dec_valid`, `dec_mask`, `dec_learn` and `flush_valid` are 0.
- R2: For a descriptor from a non-management port whose receive bit is 1, `dec_mask` equals the destination mask ANDed with the transmit bits, where bit p of a mask means port p. When the receive bit is 0 it is 0, except as R4 allows.
- R3: `dec_learn` is 1 exactly when a descriptor was valid, its source port exists, that port's learning-off bit is 0, and `frm_src_mcast` is 0.
- R4: A descriptor from a non-management port with both `frm_static_hit` and `frm_override` set always has the management port bit set in `dec_mask`. This holds whatever the receive bit of the source or the transmit bit of the management port.
- R5: For a descriptor from the management port, `dec_mask` is the destination mask restricted to ports whose transmit bit is 1 or whose learning-off bit is 0.
- R6: The source port's own bit is never set in `dec_mask`. A descriptor whose source number is not a port (at or above `NUM_PORTS`) gives a zero mask and no learning.
- R7: A control write (`cfg_ctl` bits [2:0] = {transmit, receive, learning off}) is stored as pending. It is copied to the active settings at the end of a cycle where `frm_valid` is 0. Descriptors before that copy use the old settings.
- R8: When the active copy changes a port's learning-off bit from 0 to 1, `flush_valid` pulses for one cycle with `flush_port` set to that port, in the cycle the new setting becomes active. Rewriting a 1 gives no pulse.
- R9: Flush requests raised together are issued one per cycle, lowest port number first.
- R10: Each decision appears one cycle after its descriptor, with `dec_valid` = 1. On cycles without a decision, `dec_mask` and `dec_learn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_port | input | PW | Port addressed by the write |
| cfg_ctl | input | 3 | {transmit enable, receive enable, learning off} |
| frm_valid | input | 1 | Descriptor present this cycle |
| frm_src | input | PW | Ingress port number |
| frm_dst | input | NUM_PORTS | Destination port mask from lookup |
| frm_static_hit | input | 1 | Destination matched a static table entry |
| frm_override | input | 1 | Matched static entry has its override flag |
| frm_src_mcast | input | 1 | Source address has the group bit set |
| dec_valid | output | 1 | Decision present |
| dec_mask | output | NUM_PORTS | Permitted egress ports |
| dec_learn | output | 1 | Source address may be learned |
| flush_valid | output | 1 | One-cycle flush request |
| flush_port | output | PW | Port whose table entries are to be flushed |

## Verification
A corrupted active setting shows at the ports one cycle after the next descriptor from or to the affected port, as a wrong egress bit or a wrong learn flag. The bench therefore sweeps every source number, destination mask, flag pair and multicast bit under several port-state mixes. A lost or duplicated flush bit shows in the idle cycle after the commit, as a missing, repeated or misordered `flush_port` value. A commit at the wrong moment shows in the descriptor presented right after a write.

// File: rtl/stp_gate_pkg.sv
package stp_gate_pkg;
    typedef struct packed {
        logic tx_en;
        logic rx_en;
        logic lrn_off;
    } port_ctl_t;

    localparam port_ctl_t CTL_DISCARD = '{tx_en: 1'b0, rx_en: 1'b0, lrn_off: 1'b1};
endpackage

// File: rtl/stp_ctl_bank.sv
module stp_ctl_bank
    import stp_gate_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int PW        = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PW-1:0]        wr_port,
    input  port_ctl_t            wr_ctl,
    input  logic                 commit,
    output logic [NUM_PORTS-1:0] tx_vec,
    output logic [NUM_PORTS-1:0] rx_vec,
    output logic [NUM_PORTS-1:0] lrn_off_vec,
    output logic                 flush_valid,
    output logic [PW-1:0]        flush_port
);
    typedef struct packed {
        port_ctl_t [NUM_PORTS-1:0] pend;
        port_ctl_t [NUM_PORTS-1:0] act;
        logic [NUM_PORTS-1:0]      fq;
        logic                      fval;
        logic [PW-1:0]             fport;
    } bank_t;

    bank_t s_d, s_q;
    logic [NUM_PORTS-1:0] rise;
    logic [NUM_PORTS-1:0] cand;
    logic [PW-1:0]        pick;

    always_comb begin
        s_d      = s_q;
        s_d.fval = 1'b0;
        rise     = '0;
        pick     = '0;
        if (wr_en && (int'(wr_port) < NUM_PORTS)) begin
            s_d.pend[wr_port] = wr_ctl;
        end
        if (commit) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                rise[p] = s_q.pend[p].lrn_off & ~s_q.act[p].lrn_off;
            end
            s_d.act = s_q.pend;
        end
        cand = s_q.fq | rise;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (cand[p]) pick = PW'(p);
        end
        if (|cand) begin
            s_d.fval    = 1'b1;
            s_d.fport   = pick;
            cand[pick]  = 1'b0;
        end
        s_d.fq = cand;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                s_q.pend[p] <= CTL_DISCARD;
                s_q.act[p]  <= CTL_DISCARD;
            end
            s_q.fq    <= '0;
            s_q.fval  <= 1'b0;
            s_q.fport <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_vec
        assign tx_vec[g]      = s_q.act[g].tx_en;
        assign rx_vec[g]      = s_q.act[g].rx_en;
        assign lrn_off_vec[g] = s_q.act[g].lrn_off;
    end

    assign flush_valid = s_q.fval;
    assign flush_port  = s_q.fport;

    assert_commit_on_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.act) |-> $past(commit));

    assert_flush_port_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (int'(flush_port) < NUM_PORTS));

    assert_flush_marks_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> ((s_q.fq & ((NUM_PORTS)'(1) << flush_port)) == '0));
endmodule

// File: rtl/stp_frame_decide.sv
module stp_frame_decide #(
    parameter int NUM_PORTS = 5,
    parameter int PW        = 3,
    parameter int MGMT_PORT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_valid,
    input  logic [PW-1:0]        frm_src,
    input  logic [NUM_PORTS-1:0] frm_dst,
    input  logic                 frm_static_hit,
    input  logic                 frm_override,
    input  logic                 frm_src_mcast,
    input  logic [NUM_PORTS-1:0] tx_vec,
    input  logic [NUM_PORTS-1:0] rx_vec,
    input  logic [NUM_PORTS-1:0] lrn_off_vec,
    output logic                 dec_valid,
    output logic [NUM_PORTS-1:0] dec_mask,
    output logic                 dec_learn
);
    typedef struct packed {
        logic                 valid;
        logic [NUM_PORTS-1:0] mask;
        logic                 learn;
    } dec_t;

    dec_t d_d, d_q;
    logic                 src_ok, from_mgmt, src_rx, src_lrn_off;
    logic [NUM_PORTS-1:0] src_bit, mgmt_bit, allow_vec;

    always_comb begin
        src_ok  = int'(frm_src) < NUM_PORTS;
        src_bit = '0;
        if (src_ok) src_bit[frm_src] = 1'b1;
        mgmt_bit            = '0;
        mgmt_bit[MGMT_PORT] = 1'b1;
        from_mgmt   = src_ok && (frm_src == PW'(MGMT_PORT));
        src_rx      = |(rx_vec & src_bit);
        src_lrn_off = |(lrn_off_vec & src_bit);
        allow_vec   = tx_vec | ~lrn_off_vec | mgmt_bit;

        d_d.valid = frm_valid;
        if (from_mgmt) begin
            d_d.mask = frm_dst & (tx_vec | ~lrn_off_vec);
        end else begin
            d_d.mask = src_rx ? (frm_dst & tx_vec) : '0;
            if (frm_static_hit && frm_override) d_d.mask = d_d.mask | mgmt_bit;
        end
        d_d.mask = d_d.mask & ~src_bit;
        if (!frm_valid || !src_ok) d_d.mask = '0;
        d_d.learn = frm_valid && src_ok && !src_lrn_off && !frm_src_mcast;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign dec_valid = d_q.valid;
    assign dec_mask  = d_q.mask;
    assign dec_learn = d_q.learn;

    assert_egress_allowed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> ((dec_mask & ~$past(allow_vec)) == '0));

    assert_src_not_egress_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> ((dec_mask & $past(src_bit)) == '0));

    assert_learn_unicast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_learn |-> $past(frm_valid && !frm_src_mcast));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (dec_mask == '0 && !dec_learn));
endmodule

// File: rtl/stp_port_gate.sv
module stp_port_gate
    import stp_gate_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int MGMT_PORT = 4,
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [PW-1:0]        cfg_port,
    input  logic [2:0]           cfg_ctl,
    input  logic                 frm_valid,
    input  logic [PW-1:0]        frm_src,
    input  logic [NUM_PORTS-1:0] frm_dst,
    input  logic                 frm_static_hit,
    input  logic                 frm_override,
    input  logic                 frm_src_mcast,
    output logic                 dec_valid,
    output logic [NUM_PORTS-1:0] dec_mask,
    output logic                 dec_learn,
    output logic                 flush_valid,
    output logic [PW-1:0]        flush_port
);
    logic [NUM_PORTS-1:0] tx_vec, rx_vec, lrn_off_vec;
    port_ctl_t            wr_ctl;

    assign wr_ctl = '{tx_en: cfg_ctl[2], rx_en: cfg_ctl[1], lrn_off: cfg_ctl[0]};

    stp_ctl_bank #(.NUM_PORTS(NUM_PORTS), .PW(PW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_port(cfg_port), .wr_ctl(wr_ctl),
        .commit(~frm_valid),
        .tx_vec(tx_vec), .rx_vec(rx_vec), .lrn_off_vec(lrn_off_vec),
        .flush_valid(flush_valid), .flush_port(flush_port)
    );

    stp_frame_decide #(.NUM_PORTS(NUM_PORTS), .PW(PW), .MGMT_PORT(MGMT_PORT)) u_decide (
        .clk(clk), .rst_n(rst_n),
        .frm_valid(frm_valid), .frm_src(frm_src), .frm_dst(frm_dst),
        .frm_static_hit(frm_static_hit), .frm_override(frm_override),
        .frm_src_mcast(frm_src_mcast),
        .tx_vec(tx_vec), .rx_vec(rx_vec), .lrn_off_vec(lrn_off_vec),
        .dec_valid(dec_valid), .dec_mask(dec_mask), .dec_learn(dec_learn)
    );
endmodule

// File: tb/stp_port_gate_tb.sv
`timescale 1ns/1ps
module stp_port_gate_tb;
    localparam int NP = 5;
    localparam int MG = 4;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [PW-1:0] cfg_port = '0;
    logic [2:0]    cfg_ctl = '0;
    logic          frm_valid = 1'b0;
    logic [PW-1:0] frm_src = '0;
    logic [NP-1:0] frm_dst = '0;
    logic          frm_static_hit = 1'b0, frm_override = 1'b0, frm_src_mcast = 1'b0;
    logic          dec_valid, dec_learn, flush_valid;
    logic [NP-1:0] dec_mask;
    logic [PW-1:0] flush_port;

    int n_run = 0, n_fail = 0;
    int b_tx[NP], b_rx[NP], b_lo[NP];

    always #4 clk = ~clk;

    stp_port_gate #(.NUM_PORTS(NP), .MGMT_PORT(MG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_ctl(cfg_ctl),
        .frm_valid(frm_valid), .frm_src(frm_src), .frm_dst(frm_dst),
        .frm_static_hit(frm_static_hit), .frm_override(frm_override),
        .frm_src_mcast(frm_src_mcast), .dec_valid(dec_valid), .dec_mask(dec_mask),
        .dec_learn(dec_learn), .flush_valid(flush_valid), .flush_port(flush_port)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // state: 0 discarding, 1 learning, 2 forwarding
    function automatic logic [2:0] enc(input int st);
        return (st == 2) ? 3'b110 : (st == 1) ? 3'b000 : 3'b001;
    endfunction

    task automatic set_mirror(input int p, input int st);
        b_tx[p] = (st == 2); b_rx[p] = (st == 2); b_lo[p] = (st == 0);
    endtask

    task automatic wr(input int p, input int st);
        @(negedge clk);
        cfg_we = 1'b1; cfg_port = PW'(p); cfg_ctl = enc(st);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int exp_mask(input int s, input int d, input bit h, input bit o);
        int m = 0;
        if (s >= NP) return 0;
        if (s == MG) begin
            for (int p = 0; p < NP; p++)
                if (d[p] && (b_tx[p] != 0 || b_lo[p] == 0)) m |= (1 << p);
        end else begin
            if (b_rx[s] != 0)
                for (int p = 0; p < NP; p++) if (d[p] && b_tx[p] != 0) m |= (1 << p);
            if (h && o) m |= (1 << MG);
        end
        m &= ~(1 << s);
        return m;
    endfunction

    task automatic desc_chk(input int s, input int d, input bit h, input bit o, input bit mc);
        int em; bit el; string tg;
        @(negedge clk);
        frm_valid = 1'b1; frm_src = PW'(s); frm_dst = NP'(d);
        frm_static_hit = h; frm_override = o; frm_src_mcast = mc;
        @(posedge clk); #2;
        em = exp_mask(s, d, h, o);
        el = (s < NP) && (b_lo[s] == 0) && !mc;
        tg = (s >= NP) ? "R6" : (s == MG) ? "R5" : (h && o) ? "R4" : "R2";
        chk(dec_valid == 1'b1, "R10 valid", int'(dec_valid), 1);
        chk(int'(dec_mask) == em, tg, int'(dec_mask), em);
        chk(dec_learn == el, "R3 learn", int'(dec_learn), int'(el));
    endtask

    task automatic go_idle();
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic sweep();
        for (int s = 0; s < 8; s++)
            for (int d = 0; d < 32; d++)
                for (int f = 0; f < 4; f++)
                    for (int mc = 0; mc < 2; mc++)
                        desc_chk(s, d, f[0], f[1], mc[0]);
        go_idle();
    endtask

    task automatic apply_cfg(input int s0, input int s1, input int s2, input int s3, input int s4);
        int st[NP];
        st = '{s0, s1, s2, s3, s4};
        for (int p = 0; p < NP; p++) begin
            wr(p, st[p]);
            set_mirror(p, st[p]);
        end
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", 200000, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) set_mirror(p, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        // R1 reset state
        chk(dec_valid == 0 && dec_mask == 0 && dec_learn == 0, "R1 outputs", int'(dec_mask), 0);
        chk(flush_valid == 0, "R1 flush", int'(flush_valid), 0);
        desc_chk(0, 31, 0, 0, 0);  // R1 discarding: nothing forwarded, no learning
        go_idle();

        // R10 quiet when idle
        @(posedge clk); #2;
        chk(dec_valid == 0 && dec_mask == 0 && dec_learn == 0, "R10 idle", int'(dec_mask), 0);

        // near-exhaustive sweeps under several state mixes
        sweep();                      // all discarding
        apply_cfg(2, 1, 0, 2, 2);
        sweep();
        apply_cfg(0, 2, 1, 1, 1);     // mgmt port learning: tx 0, override still reaches it (R4)
        sweep();
        apply_cfg(2, 2, 2, 2, 2);
        sweep();

        // R7: write during back-to-back descriptors is not active yet
        @(negedge clk);
        frm_valid = 1'b1; frm_src = 0; frm_dst = 5'b11111;
        frm_static_hit = 0; frm_override = 0; frm_src_mcast = 0;
        cfg_we = 1'b1; cfg_port = 1; cfg_ctl = enc(0);
        @(posedge clk); #2;
        chk(dec_mask == 5'b11110, "R7 same cycle", int'(dec_mask), 30);
        @(negedge clk); cfg_we = 1'b0;
        @(posedge clk); #2;
        chk(dec_mask == 5'b11110, "R7 pending not active", int'(dec_mask), 30);
        chk(flush_valid == 0, "R8 no early flush", int'(flush_valid), 0);
        go_idle();
        @(posedge clk); #2;
        chk(flush_valid == 1 && flush_port == 1, "R8 flush port1", int'(flush_port), 1);
        set_mirror(1, 0);
        desc_chk(0, 31, 0, 0, 0);
        chk(dec_mask == 5'b11100, "R7 applied after idle", int'(dec_mask), 28);
        chk(flush_valid == 0, "R8 single pulse", int'(flush_valid), 0);

        // R9: two rising edges committed together, plus a rewrite with no edge (R8)
        @(negedge clk);
        frm_valid = 1'b1; frm_src = 0; frm_dst = 0;
        cfg_we = 1'b1; cfg_port = 3; cfg_ctl = enc(0);
        @(negedge clk); cfg_port = 0; cfg_ctl = enc(0);
        @(negedge clk); cfg_port = 1; cfg_ctl = enc(0);
        @(negedge clk); cfg_we = 1'b0; frm_valid = 1'b0;
        @(posedge clk); #2;
        chk(flush_valid == 1 && flush_port == 0, "R9 first lowest", int'(flush_port), 0);
        @(posedge clk); #2;
        chk(flush_valid == 1 && flush_port == 3, "R9 second", int'(flush_port), 3);
        @(posedge clk); #2;
        chk(flush_valid == 0, "R8 rewrite no flush", int'(flush_valid), 0);
        set_mirror(0, 0); set_mirror(3, 0);
        desc_chk(2, 31, 0, 0, 0);
        desc_chk(0, 31, 1, 1, 0);  // R4 receive off, override to mgmt
        go_idle();

        // R8: learning back on then off again flushes again
        wr(2, 1);
        @(negedge clk);
        wr(2, 0);
        @(posedge clk); #2;
        chk(flush_valid == 1 && flush_port == 2, "R8 second edge", int'(flush_port), 2);
        set_mirror(2, 0);

        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule